// File: doc/BRIEF.md
# Network Controller Power-State Manager

This block holds the power state of a network interface device and manages the moves between full power (D0), light sleep (D1) and deep sleep (D2). A host programs it through a small register port with two addresses. The first is a control/status register that holds the mode, the ready flag, the wake source, the enables and the event flag. The second is a wake register, and a write of any value to it brings the device back to full power.

While the device sleeps, the block watches for wake events. In light sleep these are wake-frame and magic-packet pulses, and in deep sleep it is a carrier-detect level. It records which kind of event woke it, raises an event flag and, when enabled, drives a power-management event pin and a host interrupt. It also drives one clock-enable signal per clock domain.

After a wake write, the ready flag stays low for a fixed number of cycles, which models clock restart. Until ready is set, the control register ignores writes. The wake-write decode and the registers run on an always-on clock. Because of this, a wake write is accepted even while the host-bus clock enable is off.

Top module: `pwr_state_mgr`

## Requirements
- R1: After reset, the mode field (control bits 1:0) is 00 (D0), ready (bit 2) is 1, the wake source (bits 4:3) and all enables are 0, all four clock enables are 1, and pmeOut and hostIrq are 0.
- R2: A control write with mode 01 enters D1, and one with mode 10 enters D2. Ready goes to 0 on entry. Mode 11 is ignored, so the mode stays 00 and ready stays 1.
- R3: In D1, a wakeFrameDet or magicPktDet pulse sets the wake source to 10 and the event flag (bit 9) to 1. carrierDet has no effect in D1.
- R4: pmeOut is high exactly when pmeEn (bit 7) is set and either the wake source is 10 with wolEn (bit 5) set, or the wake source is 01 with edEn (bit 6) set. Clearing the source or an enable drops it.
- R5: In D2, carrierDet high at a clock edge sets the wake source to 01 and the event flag to 1. This includes a carrier already present on entry, which is seen at the first edge in D2. Wake-frame and magic-packet pulses have no effect in D2.
- R6: The event flag is set on every detection whatever pmeEn holds. hostIrq equals the event flag ANDed with irqEn (bit 8). Writing 1 to bit 9 clears the flag.
- R7: Any write to the wake register while in D1 or D2 returns the mode to 00, whatever data is written and whether or not an event occurred.
- R8: A D2 request is ignored while phyEdMode is low. The mode stays 00 and ready stays 1.
- R9: While ready is 0, control-register writes are ignored, so the mode and enables are unchanged.
- R10: Ready rises exactly READY_DLY clock edges after the edge that takes the wake write.
- R11: Clock enables per mode are: D0 sets all four to 1. D1 sets phy and macWake to 1, and macMain and bus to 0. D2 sets all four to 0.
- R12: Writing 00 to the wake-source field clears it, and a nonzero value there leaves it unchanged. Detections in D0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Register address (0 control, 1 wake) |
| hostWrData | input | 10 | Host write data |
| hostRdData | output | 10 | Read data for hostAddr |
| wakeFrameDet | input | 1 | Wake-frame match pulse |
| magicPktDet | input | 1 | Magic-packet match pulse |
| carrierDet | input | 1 | Carrier/energy present level |
| phyEdMode | input | 1 | PHY is in energy-detect mode |
| pmeOut | output | 1 | Power-management event pin |
| intStatus | output | 1 | Event status flag |
| hostIrq | output | 1 | Host interrupt |
| clkEnPhy | output | 1 | PHY clock enable |
| clkEnMacWake | output | 1 | MAC wake-logic clock enable |
| clkEnMacMain | output | 1 | Main MAC clock enable |
| clkEnBus | output | 1 | Host-bus clock enable |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Cross-state detection:** a carrier in D1 and a wake frame in D2 must leave the source at 00. A design that ignores the state would record a false wake.
- **Enable independence:** an event with pmeEn clear must still raise the event flag. A design that couples the two would lose interrupts.
- **Writes during the ready countdown:** a control write while ready is low must be dropped, so enables written then must not appear. Ready must rise on exactly the READY_DLY-th edge; an off-by-one counter shows up there.
- **Deep-sleep entry guards:** D2 must be refused without phyEdMode. With a carrier already present on entry, it must be detected on the first D2 edge, or the device would never wake.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic [1:0] {
    PM_D0 = 2'b00,
    PM_D1 = 2'b01,
    PM_D2 = 2'b10
  } pm_mode_e;

  localparam int CSR_W     = 10;
  localparam int MODE_LSB  = 0;
  localparam int READY_BIT = 2;
  localparam int SRC_LSB   = 3;
  localparam int WOL_BIT   = 5;
  localparam int ED_BIT    = 6;
  localparam int PME_BIT   = 7;
  localparam int IRQ_BIT   = 8;
  localparam int INT_BIT   = 9;

  localparam logic [1:0] SRC_NONE = 2'b00;
  localparam logic [1:0] SRC_ED   = 2'b01;
  localparam logic [1:0] SRC_WOL  = 2'b10;

  typedef struct packed {
    logic csrWr;
    logic inD1;
    logic inD2;
  } psm_strobe_t;
endpackage

// File: rtl/psm_ctrl.sv
module psm_ctrl
  import psm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CSR_ADDR  = 0,
  parameter int WAKE_ADDR = 1,
  parameter int READY_DLY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        modeReq,
  input  logic              phyEdMode,
  output psm_strobe_t       strobe,
  output pm_mode_e          mode,
  output logic              ready,
  output logic              clkEnPhy,
  output logic              clkEnMacWake,
  output logic              clkEnMacMain,
  output logic              clkEnBus
);
  localparam int CNT_W = $clog2(READY_DLY + 1);

  logic [CNT_W-1:0] cnt;
  logic wakeWr, csrWrAcc;

  assign wakeWr   = hostWrEn && (hostAddr == ADDR_W'(WAKE_ADDR));
  assign csrWrAcc = hostWrEn && (hostAddr == ADDR_W'(CSR_ADDR)) && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= PM_D0;
      ready <= 1'b1;
      cnt   <= '0;
    end else if (wakeWr && mode != PM_D0) begin
      mode  <= PM_D0;
      ready <= 1'b0;
      cnt   <= CNT_W'(READY_DLY);
    end else if (csrWrAcc) begin
      if (modeReq == PM_D1) begin
        mode  <= PM_D1;
        ready <= 1'b0;
      end else if (modeReq == PM_D2 && phyEdMode) begin
        mode  <= PM_D2;
        ready <= 1'b0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) ready <= 1'b1;
    end
  end

  assign strobe.csrWr = csrWrAcc;
  assign strobe.inD1  = (mode == PM_D1);
  assign strobe.inD2  = (mode == PM_D2);

  assign clkEnPhy     = (mode != PM_D2);
  assign clkEnMacWake = (mode != PM_D2);
  assign clkEnMacMain = (mode == PM_D0);
  assign clkEnBus     = (mode == PM_D0);

  // R2
  a_r2_ready_low_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_D0) |-> !ready);
  // R7
  a_r7_wake_to_d0: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && hostAddr == ADDR_W'(WAKE_ADDR) && mode != PM_D0) |=> (mode == PM_D0));
  // R8
  a_r8_d2_needs_ed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_D2 && $past(mode) != PM_D2) |-> $past(phyEdMode));
  // R10
  a_r10_ready_only_in_d0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (mode == PM_D0 && $past(mode) == PM_D0));
endmodule

// File: rtl/psm_datapath.sv
module psm_datapath
  import psm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  psm_strobe_t      strobe,
  input  logic [CSR_W-1:0] wrData,
  input  pm_mode_e         mode,
  input  logic             ready,
  input  logic             wakeFrameDet,
  input  logic             magicPktDet,
  input  logic             carrierDet,
  output logic [CSR_W-1:0] csrVal,
  output logic             pmeOut,
  output logic             intStatus,
  output logic             hostIrq
);
  logic [1:0] wakeSrc;
  logic wolEn, edEn, pmeEn, irqEn;
  logic detD1, detD2;

  assign detD1 = strobe.inD1 && (wakeFrameDet || magicPktDet);
  assign detD2 = strobe.inD2 && carrierDet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wakeSrc   <= SRC_NONE;
      intStatus <= 1'b0;
      wolEn     <= 1'b0;
      edEn      <= 1'b0;
      pmeEn     <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (strobe.csrWr) begin
        wolEn <= wrData[WOL_BIT];
        edEn  <= wrData[ED_BIT];
        pmeEn <= wrData[PME_BIT];
        irqEn <= wrData[IRQ_BIT];
        if (wrData[SRC_LSB+:2] == SRC_NONE) wakeSrc <= SRC_NONE;
        if (wrData[INT_BIT]) intStatus <= 1'b0;
      end
      if (detD1) begin
        wakeSrc   <= SRC_WOL;
        intStatus <= 1'b1;
      end else if (detD2) begin
        wakeSrc   <= SRC_ED;
        intStatus <= 1'b1;
      end
    end
  end

  assign pmeOut  = pmeEn && ((wakeSrc == SRC_WOL && wolEn) || (wakeSrc == SRC_ED && edEn));
  assign hostIrq = intStatus && irqEn;

  always_comb begin
    csrVal = '0;
    csrVal[MODE_LSB+:2] = mode;
    csrVal[READY_BIT]   = ready;
    csrVal[SRC_LSB+:2]  = wakeSrc;
    csrVal[WOL_BIT]     = wolEn;
    csrVal[ED_BIT]      = edEn;
    csrVal[PME_BIT]     = pmeEn;
    csrVal[IRQ_BIT]     = irqEn;
    csrVal[INT_BIT]     = intStatus;
  end

  // R3
  a_r3_d1_source: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_D1 && (wakeFrameDet || magicPktDet)) |=> (wakeSrc == SRC_WOL));
  // R5
  a_r5_d2_source: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_D2 && carrierDet) |=> (wakeSrc == SRC_ED));
  // R6
  a_r6_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PM_D1 && (wakeFrameDet || magicPktDet)) || (mode == PM_D2 && carrierDet))
    |=> intStatus);
  // R9
  a_r9_locked_while_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable({wolEn, edEn, pmeEn, irqEn}));
endmodule

// File: rtl/pwr_state_mgr.sv
module pwr_state_mgr
  import psm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CSR_ADDR  = 0,
  parameter int WAKE_ADDR = 1,
  parameter int READY_DLY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [CSR_W-1:0]  hostWrData,
  output logic [CSR_W-1:0]  hostRdData,
  input  logic              wakeFrameDet,
  input  logic              magicPktDet,
  input  logic              carrierDet,
  input  logic              phyEdMode,
  output logic              pmeOut,
  output logic              intStatus,
  output logic              hostIrq,
  output logic              clkEnPhy,
  output logic              clkEnMacWake,
  output logic              clkEnMacMain,
  output logic              clkEnBus
);
  psm_strobe_t      strobe;
  pm_mode_e         mode;
  logic             ready;
  logic [CSR_W-1:0] csrVal;

  psm_ctrl #(
    .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .WAKE_ADDR(WAKE_ADDR), .READY_DLY(READY_DLY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .modeReq(hostWrData[MODE_LSB+:2]), .phyEdMode(phyEdMode),
    .strobe(strobe), .mode(mode), .ready(ready),
    .clkEnPhy(clkEnPhy), .clkEnMacWake(clkEnMacWake),
    .clkEnMacMain(clkEnMacMain), .clkEnBus(clkEnBus)
  );

  psm_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(hostWrData),
    .mode(mode), .ready(ready), .wakeFrameDet(wakeFrameDet),
    .magicPktDet(magicPktDet), .carrierDet(carrierDet), .csrVal(csrVal),
    .pmeOut(pmeOut), .intStatus(intStatus), .hostIrq(hostIrq)
  );

  assign hostRdData = (hostAddr == ADDR_W'(CSR_ADDR)) ? csrVal : '0;
endmodule

// File: tb/pwr_state_mgr_bench.sv
module pwr_state_mgr_bench;
  localparam int DLY = 8;

  logic clk = 0, rst_n = 0;
  logic hostWrEn = 0;
  logic [1:0] hostAddr = 0;
  logic [9:0] hostWrData = 0;
  logic [9:0] hostRdData;
  logic wakeFrameDet = 0, magicPktDet = 0, carrierDet = 0, phyEdMode = 1;
  logic pmeOut, intStatus, hostIrq, clkEnPhy, clkEnMacWake, clkEnMacMain, clkEnBus;

  int nChecks = 0, nFail = 0;

  always #10 clk = ~clk;

  pwr_state_mgr #(.READY_DLY(DLY)) u_pwr_state_mgr (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .wakeFrameDet(wakeFrameDet), .magicPktDet(magicPktDet), .carrierDet(carrierDet),
    .phyEdMode(phyEdMode), .pmeOut(pmeOut), .intStatus(intStatus), .hostIrq(hostIrq),
    .clkEnPhy(clkEnPhy), .clkEnMacWake(clkEnMacWake),
    .clkEnMacMain(clkEnMacMain), .clkEnBus(clkEnBus)
  );

  // vector: mode[10:9] det[8:7] wol[6] ed[5] pme[4] expSrc[3:2] expPme[1] expInt[0]
  // det: 0 none, 1 wake frame, 2 magic packet, 3 carrier
  localparam logic [10:0] VEC [8] = '{
    {2'b01, 2'd1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1},
    {2'b01, 2'd2, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1},
    {2'b01, 2'd2, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1},
    {2'b10, 2'd3, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1},
    {2'b10, 2'd3, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1},
    {2'b01, 2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0},
    {2'b10, 2'd1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0},
    {2'b01, 2'd0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0}
  };

  function automatic logic [9:0] mkCsr(logic [1:0] md, logic [1:0] src, logic wol,
                                       logic ed, logic pme, logic irq, logic intc);
    return {intc, irq, pme, ed, wol, src, 1'b0, md};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [9:0] d);
    @(negedge clk);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 0; hostAddr = 0;
  endtask

  task automatic pulse(logic [1:0] det);
    @(negedge clk);
    wakeFrameDet = (det == 2'd1);
    magicPktDet  = (det == 2'd2);
    carrierDet   = (det == 2'd3);
    @(negedge clk);
    wakeFrameDet = 0; magicPktDet = 0; carrierDet = 0;
  endtask

  task automatic wakeAndWait(string tag);
    wr(2'd1, 10'h2a5);
    chk({tag, " R7 mode after wake"}, 16'(hostRdData[1:0]), 16'h0);
    chk({tag, " R10 ready low just after wake"}, 16'(hostRdData[2]), 16'h0);
    repeat (DLY - 1) @(negedge clk);
    chk({tag, " R10 ready one edge early"}, 16'(hostRdData[2]), 16'h0);
    @(negedge clk);
    chk({tag, " R10 ready at delay"}, 16'(hostRdData[2]), 16'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 csr", 16'(hostRdData), 16'h004);
    chk("R1 clocks", 16'({clkEnPhy, clkEnMacWake, clkEnMacMain, clkEnBus}), 16'hf);
    chk("R1 pme irq", 16'({pmeOut, hostIrq}), 16'h0);

    // table of sleep/detect cases
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      wr(2'd0, mkCsr(v[10:9], 2'b11, v[6], v[5], v[4], 1'b1, 1'b0));
      chk($sformatf("R2 vec%0d mode", i), 16'(hostRdData[1:0]), 16'(v[10:9]));
      chk($sformatf("R2 vec%0d ready", i), 16'(hostRdData[2]), 16'h0);
      pulse(v[8:7]);
      chk($sformatf("R3 R5 vec%0d src", i), 16'(hostRdData[4:3]), 16'(v[3:2]));
      chk($sformatf("R4 vec%0d pme", i), 16'(pmeOut), 16'(v[1]));
      chk($sformatf("R6 vec%0d flag", i), 16'(intStatus), 16'(v[0]));
      chk($sformatf("R6 vec%0d irq", i), 16'(hostIrq), 16'(v[0]));
      wakeAndWait($sformatf("vec%0d", i));
      chk($sformatf("R12 vec%0d src kept", i), 16'(hostRdData[4:3]), 16'(v[3:2]));
      wr(2'd0, mkCsr(2'b00, 2'b00, v[6], v[5], v[4], 1'b1, 1'b1));
      chk($sformatf("R12 vec%0d src cleared", i), 16'(hostRdData[4:3]), 16'h0);
      chk($sformatf("R4 vec%0d pme off", i), 16'(pmeOut), 16'h0);
      chk($sformatf("R6 vec%0d flag cleared", i), 16'(intStatus), 16'h0);
    end

    // R2 mode 11 ignored
    wr(2'd0, mkCsr(2'b11, 2'b00, 0, 0, 0, 0, 0));
    chk("R2 mode 11 ignored", 16'(hostRdData[2:0]), 16'h4);

    // R8 D2 refused without PHY energy-detect mode
    phyEdMode = 0;
    wr(2'd0, mkCsr(2'b10, 2'b00, 0, 1, 1, 0, 0));
    chk("R8 d2 refused", 16'(hostRdData[2:0]), 16'h4);
    phyEdMode = 1;

    // R12 detection in D0 ignored
    pulse(2'd1);
    pulse(2'd3);
    chk("R12 d0 detect ignored", 16'({hostRdData[4:3], intStatus}), 16'h0);

    // R11 clocks in D1, R9 writes ignored while not ready
    wr(2'd0, mkCsr(2'b01, 2'b00, 1, 0, 0, 0, 0));
    chk("R11 d1 clocks", 16'({clkEnPhy, clkEnMacWake, clkEnMacMain, clkEnBus}), 16'hc);
    wr(2'd0, mkCsr(2'b00, 2'b00, 1, 1, 1, 1, 0));
    chk("R9 write in d1 ignored", 16'(hostRdData), 16'h021);
    pulse(2'd1);
    chk("R4 pme needs pme enable", 16'(pmeOut), 16'h0);
    wr(2'd1, 10'h000);
    wr(2'd0, mkCsr(2'b00, 2'b00, 0, 1, 1, 1, 0));
    chk("R9 write during countdown ignored", 16'(hostRdData[8:5]), 16'h1);
    repeat (DLY) @(negedge clk);
    chk("R10 ready after countdown", 16'(hostRdData[2]), 16'h1);
    // R12 nonzero source write keeps source; R4 enable removal drops pin
    wr(2'd0, mkCsr(2'b00, 2'b01, 1, 0, 1, 0, 0));
    chk("R12 nonzero write keeps src", 16'(hostRdData[4:3]), 16'h2);
    chk("R4 pme on after enable", 16'(pmeOut), 16'h1);
    wr(2'd0, mkCsr(2'b00, 2'b10, 0, 0, 1, 0, 0));
    chk("R4 pme off on wol disable", 16'(pmeOut), 16'h0);
    wr(2'd0, mkCsr(2'b00, 2'b00, 0, 0, 0, 0, 1));

    // R5 carrier present on D2 entry, R11 clocks in D2, wake frame ignored in D2
    carrierDet = 1;
    wr(2'd0, mkCsr(2'b10, 2'b00, 0, 1, 1, 1, 0));
    chk("R11 d2 clocks", 16'({clkEnPhy, clkEnMacWake, clkEnMacMain, clkEnBus}), 16'h0);
    @(negedge clk);
    carrierDet = 0;
    chk("R5 carrier on entry", 16'(hostRdData[4:3]), 16'h1);
    chk("R5 pme on entry", 16'(pmeOut), 16'h1);
    pulse(2'd1);
    chk("R5 wake frame in d2 ignored", 16'(hostRdData[4:3]), 16'h1);
    wakeAndWait("d2 entry");
    chk("R11 d0 clocks back", 16'({clkEnPhy, clkEnMacWake, clkEnMacMain, clkEnBus}), 16'hf);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule